// File: doc/BRIEF.md
# VGA Planar Memory Read Path

This block serves single-byte CPU reads from the 128 KiB legacy video window. A bus address is reduced to a window offset and placed through one of four memory-map apertures. The offset is then turned into a video-memory access according to the active addressing scheme: chain-4, odd/even, or plain planar. The block returns one byte per request after a fixed single cycle.

Video memory is presented as a word-wide store of four byte planes. Plane p occupies bits [8p+7:8p] of each 32-bit word. The memory returns the word one cycle after its read enable.

On a planar read, the block captures the whole fetched word in its latch. The latch is exported for the write datapath, which sits elsewhere. Planar reads either return one plane of the word or run a four-plane colour comparison that yields one bit per pixel.

Top module: `vga_plane_reader`

## Requirements
- R1: The window offset is the bus address modulo 0x20000. The map-mode field selects the aperture. Value 0 accepts every offset with base 0. Value 1 accepts offsets below 0x10000 with base 0. Value 2 subtracts 0x10000 and accepts results below 0x8000. Value 3 subtracts 0x18000 and accepts results below 0x8000.
- R2: A read outside the selected aperture returns 0xFF. It issues no memory read and leaves the latch unchanged.
- R3: `rd_valid` is high in exactly the cycle after each cycle with `rd_req` high, and in no other cycle. `rd_data` is meaningful in that cycle.
- R4: When `seq_chain4` is 1, chain-4 takes priority over the other schemes. The memory word address is the relative offset shifted right by 2, and the returned byte is the plane given by offset bits [1:0]. The latch is unchanged.
- R5: When `seq_chain4` is 0 and `gfx_odd_even` is 1, the plane is {`gfx_read_plane`[1], offset bit 0}. The word address is the relative offset shifted right by 1, and the returned byte is that plane's byte. The latch is unchanged.
- R6: When neither scheme is on, the word at the relative offset is read. It is loaded into the latch, which shows it on `latch_o` from the cycle after `rd_valid`.
- R7: In a planar read with `gfx_cmp_mode` 0, the byte returned is plane `gfx_read_plane` of the fetched word.
- R8: In a planar read with `gfx_cmp_mode` 1, bit i of the result is 1 exactly when every plane p with `gfx_color_care`[p]=1 has bit i equal to `gfx_color_cmp`[p].
- R9: After reset, `latch_o` is 0 and both `rd_valid` and `mem_rd_en` are 0.
- R10: `mem_rd_en` is high only in a cycle with `rd_req` high and an in-aperture address, and `mem_rd_addr` is valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_req | input | 1 | Byte read request, one cycle |
| rd_addr | input | ADDR_W | Bus address of the byte |
| gfx_map_mode | input | 2 | Aperture select |
| gfx_odd_even | input | 1 | Odd/even addressing on |
| gfx_cmp_mode | input | 1 | 0: plane read, 1: colour compare |
| gfx_read_plane | input | 2 | Plane for plane reads; bit 1 also used in odd/even |
| gfx_color_cmp | input | PLANES | Colour value per plane |
| gfx_color_care | input | PLANES | Planes taking part in the compare |
| seq_chain4 | input | 1 | Chain-4 addressing on |
| mem_rd_en | output | 1 | Memory read enable |
| mem_rd_addr | output | WIN_AW | Memory word address |
| mem_rd_data | input | PLANES*LANE_W | Word returned one cycle after enable |
| rd_valid | output | 1 | Returned byte valid |
| rd_data | output | LANE_W | Returned byte |
| latch_o | output | PLANES*LANE_W | Latch contents |

## Verification
Two situations are hard to reach from the ports: reads that fall one byte on either side of an aperture edge, and the latch staying put across non-planar or missed reads. Directed reads sit on both sides of every aperture boundary and use addresses above 0x1FFFF, so the modulo folding is exercised. The random phase mixes all three schemes and random compare masks, including all-clear masks. The bench keeps its own copy of the latch and checks `latch_o` after every read, so a stray latch load is caught on the next check.

// File: rtl/vga_rd_pkg.sv
package vga_rd_pkg;
   typedef enum logic [1:0] {
      ACC_MISS    = 2'd0,
      ACC_CHAIN   = 2'd1,
      ACC_ODDEVEN = 2'd2,
      ACC_PLANAR  = 2'd3
   } acc_kind_t;
endpackage

// File: rtl/vga_win_decode.sv
module vga_win_decode #(
   parameter int ADDR_W = 20,
   parameter int WIN_AW = 17
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        map_mode,
   output logic              hit,
   output logic [WIN_AW-1:0] rel_off
);
   localparam longint SPAN    = 64'd1 << WIN_AW;
   localparam logic [WIN_AW:0]   LIM_FULL = (WIN_AW+1)'(SPAN);
   localparam logic [WIN_AW:0]   LIM_HALF = (WIN_AW+1)'(SPAN / 2);
   localparam logic [WIN_AW:0]   LIM_QTR  = (WIN_AW+1)'(SPAN / 4);
   localparam logic [WIN_AW-1:0] BASE_HI  = WIN_AW'(SPAN / 2);
   localparam logic [WIN_AW-1:0] BASE_TOP = WIN_AW'(SPAN / 2 + SPAN / 4);

   logic [WIN_AW-1:0] off;
   logic [WIN_AW-1:0] base;
   logic [WIN_AW:0]   lim;

   always_comb begin
      off = addr[WIN_AW-1:0];
      case (map_mode)
         2'd0:    begin base = '0;       lim = LIM_FULL; end
         2'd1:    begin base = '0;       lim = LIM_HALF; end
         2'd2:    begin base = BASE_HI;  lim = LIM_QTR;  end
         default: begin base = BASE_TOP; lim = LIM_QTR;  end
      endcase
      rel_off = off - base;
      hit     = ({1'b0, rel_off} < lim);
   end
endmodule

// File: rtl/vga_addr_gen.sv
module vga_addr_gen
   import vga_rd_pkg::*;
#(
   parameter int WIN_AW = 17,
   parameter int PLANES = 4,
   localparam int PL_W  = $clog2(PLANES)
) (
   input  logic [WIN_AW-1:0] rel_off,
   input  logic              chain4,
   input  logic              odd_even,
   input  logic [PL_W-1:0]   read_plane,
   output acc_kind_t         kind,
   output logic [WIN_AW-1:0] word_addr,
   output logic [PL_W-1:0]   lane
);
   always_comb begin
      if (chain4) begin
         kind      = ACC_CHAIN;
         word_addr = rel_off >> PL_W;
         lane      = rel_off[PL_W-1:0];
      end else if (odd_even) begin
         kind      = ACC_ODDEVEN;
         word_addr = rel_off >> 1;
         lane      = {read_plane[PL_W-1:1], rel_off[0]};
      end else begin
         kind      = ACC_PLANAR;
         word_addr = rel_off;
         lane      = read_plane;
      end
   end
endmodule

// File: rtl/vga_byte_select.sv
module vga_byte_select
   import vga_rd_pkg::*;
#(
   parameter int PLANES = 4,
   parameter int LANE_W = 8,
   localparam int PL_W   = $clog2(PLANES),
   localparam int DATA_W = PLANES * LANE_W
) (
   input  logic [DATA_W-1:0] word,
   input  acc_kind_t         kind,
   input  logic [PL_W-1:0]   lane,
   input  logic              cmp_mode,
   input  logic [PLANES-1:0] cmp_color,
   input  logic [PLANES-1:0] care,
   output logic [LANE_W-1:0] byte_out
);
   logic [LANE_W-1:0] plane_diff [PLANES];
   logic [LANE_W-1:0] plane_byte [PLANES];
   logic [LANE_W-1:0] mismatch;

   for (genvar p = 0; p < PLANES; p++) begin : g_plane
      assign plane_byte[p] = word[p*LANE_W +: LANE_W];
      assign plane_diff[p] = (plane_byte[p] ^ {LANE_W{cmp_color[p]}})
                             & {LANE_W{care[p]}};
   end

   always_comb begin
      mismatch = '0;
      for (int p = 0; p < PLANES; p++) begin
         mismatch = mismatch | plane_diff[p];
      end
   end

   always_comb begin
      if (kind == ACC_MISS) begin
         byte_out = '1;
      end else if (kind == ACC_PLANAR && cmp_mode) begin
         byte_out = ~mismatch;
      end else begin
         byte_out = plane_byte[lane];
      end
   end
endmodule

// File: rtl/vga_plane_reader.sv
module vga_plane_reader
   import vga_rd_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int WIN_AW = 17,
   parameter int PLANES = 4,
   parameter int LANE_W = 8,
   localparam int DATA_W = PLANES * LANE_W,
   localparam int PL_W   = $clog2(PLANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_req,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [1:0]        gfx_map_mode,
   input  logic              gfx_odd_even,
   input  logic              gfx_cmp_mode,
   input  logic [PL_W-1:0]   gfx_read_plane,
   input  logic [PLANES-1:0] gfx_color_cmp,
   input  logic [PLANES-1:0] gfx_color_care,
   input  logic              seq_chain4,
   output logic              mem_rd_en,
   output logic [WIN_AW-1:0] mem_rd_addr,
   input  logic [DATA_W-1:0] mem_rd_data,
   output logic              rd_valid,
   output logic [LANE_W-1:0] rd_data,
   output logic [DATA_W-1:0] latch_o
);
   if (PLANES != 4) begin : g_bad_planes
      $error("vga_plane_reader: odd/even and chain-4 need exactly four planes");
   end
   if (ADDR_W < WIN_AW) begin : g_bad_addr
      $error("vga_plane_reader: bus address narrower than the window");
   end
   if (WIN_AW < 4) begin : g_bad_win
      $error("vga_plane_reader: window too small for four apertures");
   end

   logic              win_hit;
   logic [WIN_AW-1:0] rel_off;
   acc_kind_t         gen_kind;
   logic [WIN_AW-1:0] gen_addr;
   logic [PL_W-1:0]   gen_lane;

   vga_win_decode #(.ADDR_W(ADDR_W), .WIN_AW(WIN_AW)) u_win (
      .addr     (rd_addr),
      .map_mode (gfx_map_mode),
      .hit      (win_hit),
      .rel_off  (rel_off)
   );

   vga_addr_gen #(.WIN_AW(WIN_AW), .PLANES(PLANES)) u_agen (
      .rel_off    (rel_off),
      .chain4     (seq_chain4),
      .odd_even   (gfx_odd_even),
      .read_plane (gfx_read_plane),
      .kind       (gen_kind),
      .word_addr  (gen_addr),
      .lane       (gen_lane)
   );

   assign mem_rd_en   = rd_req && win_hit;
   assign mem_rd_addr = gen_addr;

   acc_kind_t         s_kind;
   logic              s_valid;
   logic [PL_W-1:0]   s_lane;
   logic              s_cmp_mode;
   logic [PLANES-1:0] s_cmp;
   logic [PLANES-1:0] s_care;
   logic [DATA_W-1:0] latch_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_valid    <= 1'b0;
         s_kind     <= ACC_MISS;
         s_lane     <= '0;
         s_cmp_mode <= 1'b0;
         s_cmp      <= '0;
         s_care     <= '0;
      end else begin
         s_valid <= rd_req;
         if (rd_req) begin
            s_kind     <= win_hit ? gen_kind : ACC_MISS;
            s_lane     <= gen_lane;
            s_cmp_mode <= gfx_cmp_mode;
            s_cmp      <= gfx_color_cmp;
            s_care     <= gfx_color_care;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
      end else if (s_valid && s_kind == ACC_PLANAR) begin
         latch_q <= mem_rd_data;
      end
   end

   vga_byte_select #(.PLANES(PLANES), .LANE_W(LANE_W)) u_sel (
      .word      (mem_rd_data),
      .kind      (s_kind),
      .lane      (s_lane),
      .cmp_mode  (s_cmp_mode),
      .cmp_color (s_cmp),
      .care      (s_care),
      .byte_out  (rd_data)
   );

   assign rd_valid = s_valid;
   assign latch_o  = latch_q;
endmodule

// File: rtl/vga_plane_reader_chk.sv
module vga_plane_reader_chk #(
   parameter int DATA_W = 32,
   parameter int LANE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_req,
   input logic              seq_chain4,
   input logic              gfx_odd_even,
   input logic              mem_rd_en,
   input logic              rd_valid,
   input logic [LANE_W-1:0] rd_data,
   input logic [DATA_W-1:0] latch_o
);
   AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rd_valid); // R3
   AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !rd_valid); // R3
   AST_FETCH_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> rd_req); // R10
   AST_MISS_RETURNS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !mem_rd_en) |=> (rd_data == {LANE_W{1'b1}})); // R2
   AST_MISS_KEEPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !mem_rd_en) |=> ##1 $stable(latch_o)); // R2
   AST_CHAIN_KEEPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && seq_chain4) |=> ##1 $stable(latch_o)); // R4
   AST_ODDEVEN_KEEPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !seq_chain4 && gfx_odd_even) |=> ##1 $stable(latch_o)); // R5
   AST_IDLE_KEEPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |=> $stable(latch_o)); // R6
endmodule

bind vga_plane_reader vga_plane_reader_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .rd_req       (rd_req),
   .seq_chain4   (seq_chain4),
   .gfx_odd_even (gfx_odd_even),
   .mem_rd_en    (mem_rd_en),
   .rd_valid     (rd_valid),
   .rd_data      (rd_data),
   .latch_o      (latch_o)
);

// File: tb/sim_vga_plane_reader.sv
module sim_vga_plane_reader;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_req = 1'b0;
   logic [19:0] rd_addr = '0;
   logic [1:0]  gfx_map_mode = '0;
   logic        gfx_odd_even = 1'b0;
   logic        gfx_cmp_mode = 1'b0;
   logic [1:0]  gfx_read_plane = '0;
   logic [3:0]  gfx_color_cmp = '0;
   logic [3:0]  gfx_color_care = '0;
   logic        seq_chain4 = 1'b0;
   logic        mem_rd_en;
   logic [16:0] mem_rd_addr;
   logic [31:0] mem_rd_data;
   logic        rd_valid;
   logic [7:0]  rd_data;
   logic [31:0] latch_o;

   int checks = 0;
   int errors = 0;
   logic [31:0] model_latch = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vga_plane_reader u0 (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
      .gfx_map_mode(gfx_map_mode), .gfx_odd_even(gfx_odd_even),
      .gfx_cmp_mode(gfx_cmp_mode), .gfx_read_plane(gfx_read_plane),
      .gfx_color_cmp(gfx_color_cmp), .gfx_color_care(gfx_color_care),
      .seq_chain4(seq_chain4), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
      .mem_rd_data(mem_rd_data), .rd_valid(rd_valid), .rd_data(rd_data),
      .latch_o(latch_o)
   );

   function automatic logic [31:0] memf(input logic [16:0] a);
      logic [31:0] x;
      x = {15'h0, a} * 32'h9E37_79B1;
      return x ^ (x >> 15) ^ 32'h3C5A_0F96;
   endfunction

   always_ff @(posedge clk) begin
      if (mem_rd_en) mem_rd_data <= memf(mem_rd_addr);
      else           mem_rd_data <= 32'hA5A5_5A5A;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // expected result of one read, from the requirements
   task automatic predict(output logic hit, output logic [7:0] byte_exp,
                          output logic planar, output logic [31:0] word);
      logic [16:0] off, rel;
      logic [1:0]  pl;
      off = rd_addr[16:0];
      planar = 1'b0;
      word = '0;
      case (gfx_map_mode)
         2'd0: begin rel = off;             hit = 1'b1; end
         2'd1: begin rel = off;             hit = off < 17'h10000; end
         2'd2: begin rel = off - 17'h10000; hit = rel < 17'h08000; end
         default: begin rel = off - 17'h18000; hit = rel < 17'h08000; end
      endcase
      byte_exp = 8'hFF;
      if (hit) begin
         if (seq_chain4) begin
            word = memf(rel >> 2);
            byte_exp = word[rel[1:0]*8 +: 8];
         end else if (gfx_odd_even) begin
            pl = {gfx_read_plane[1], rel[0]};
            word = memf(rel >> 1);
            byte_exp = word[pl*8 +: 8];
         end else begin
            planar = 1'b1;
            word = memf(rel);
            if (!gfx_cmp_mode) begin
               byte_exp = word[gfx_read_plane*8 +: 8];
            end else begin
               for (int i = 0; i < 8; i++) begin
                  byte_exp[i] = 1'b1;
                  for (int p = 0; p < 4; p++)
                     if (gfx_color_care[p] && (word[p*8+i] != gfx_color_cmp[p]))
                        byte_exp[i] = 1'b0;
               end
            end
         end
      end
   endtask

   // inputs are set by the caller before the negedge; one read, then idle
   task automatic do_read(input string req);
      logic hit, planar;
      logic [7:0] bexp;
      logic [31:0] w;
      predict(hit, bexp, planar, w);
      rd_req = 1'b1;
      #1;
      check({req, " R10 fetch enable"}, {31'h0, mem_rd_en}, {31'h0, hit});
      @(negedge clk);
      rd_req = 1'b0;
      check({req, " R3 valid"}, {31'h0, rd_valid}, 32'h1);
      check({req, " data"}, {24'h0, rd_data}, {24'h0, bexp});
      if (planar) model_latch = w;
      @(negedge clk);
      check({req, " R6 latch"}, latch_o, model_latch);
      check({req, " R3 no extra valid"}, {31'h0, rd_valid}, 32'h0);
   endtask

   task automatic set_mode(input logic c4, input logic oe, input logic [1:0] mm,
                           input logic cm, input logic [1:0] rp,
                           input logic [3:0] cc, input logic [3:0] ca);
      seq_chain4 = c4; gfx_odd_even = oe; gfx_map_mode = mm; gfx_cmp_mode = cm;
      gfx_read_plane = rp; gfx_color_cmp = cc; gfx_color_care = ca;
   endtask

   bit done = 0;
   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = 32'h1234_ABCD;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      check("R9 reset valid", {31'h0, rd_valid}, 32'h0);
      check("R9 reset latch", latch_o, 32'h0);
      check("R9 reset fetch", {31'h0, mem_rd_en}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1/R2 aperture edges, planar mode 0
      set_mode(0, 0, 2'd1, 0, 2'd2, 4'h0, 4'h0);
      rd_addr = 20'h0FFFF; do_read("R1 mode1 last");
      rd_addr = 20'h10000; do_read("R2 mode1 miss");
      set_mode(0, 0, 2'd2, 0, 2'd1, 4'h0, 4'h0);
      rd_addr = 20'h0FFFF; do_read("R2 mode2 below");
      rd_addr = 20'h10000; do_read("R1 mode2 first");
      rd_addr = 20'h17FFF; do_read("R1 mode2 last");
      rd_addr = 20'h18000; do_read("R2 mode2 above");
      set_mode(0, 0, 2'd3, 0, 2'd3, 4'h0, 4'h0);
      rd_addr = 20'h17FFF; do_read("R2 mode3 below");
      rd_addr = 20'h18000; do_read("R1 mode3 first");
      rd_addr = 20'h1FFFF; do_read("R1 mode3 last");
      set_mode(0, 0, 2'd0, 0, 2'd0, 4'h0, 4'h0);
      rd_addr = 20'h3_0005; do_read("R1 modulo fold");
      rd_addr = 20'h1FFFF; do_read("R7 plane0");
      // R4 chain-4 wins over odd/even
      set_mode(1, 1, 2'd0, 0, 2'd0, 4'h0, 4'h0);
      rd_addr = 20'h00007; do_read("R4 chain4");
      // R5 odd/even with high plane bit
      set_mode(0, 1, 2'd0, 0, 2'd2, 4'h0, 4'h0);
      rd_addr = 20'h00123; do_read("R5 oddeven odd");
      rd_addr = 20'h00124; do_read("R5 oddeven even");
      // R8 compare with nothing cared for gives all ones
      set_mode(0, 0, 2'd0, 1, 2'd0, 4'hA, 4'h0);
      rd_addr = 20'h00456; do_read("R8 care none");
      set_mode(0, 0, 2'd0, 1, 2'd0, 4'h5, 4'hF);
      rd_addr = 20'h00457; do_read("R8 care all");

      for (int n = 0; n < 3000; n++) begin
         logic [31:0] r;
         r = $urandom;
         set_mode(r[0] & r[1], r[2], r[4:3], r[5], r[7:6], r[11:8], r[15:12]);
         rd_addr = 20'($urandom);
         do_read("R4 R5 R7 R8 random");
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule